// File: doc/BRIEF.md
# Exception Frame Stacking Sequencer

This block is the processor-side sequencer that enters and leaves an exception through a 32-bit stack held in memory. An entry request captures the current status register, stack pointer, program counter, vector base, exception index and a hardware-interrupt flag with its priority level. The sequencer then builds a frame descriptor word and aligns the stack pointer downward to a longword boundary. It writes two longwords below that boundary and reads the handler address from the vector table. It reports the new status register, stack pointer and program counter.

A return request reads a frame back from the given stack pointer and restores all three values. The original misalignment of the stack pointer is kept in the descriptor word, so a return undoes an entry exactly.

Memory is reached through a request/acknowledge word port with one access outstanding at a time.

States:
- `ST_IDLE`: waits for a start pulse.
- `ST_PUSH_PC`: writes the return address.
- `ST_PUSH_FMT`: writes the descriptor.
- `ST_FETCH_VEC`: reads the handler address.
- `ST_POP_FMT`: reads the descriptor back.
- `ST_POP_PC`: reads the saved address.
- `ST_FINISH`: a one-cycle completion state.

Transitions:
- Idle moves to `ST_PUSH_PC` when `start_entry` is sampled.
- Idle moves to `ST_POP_FMT` when only `start_return` is sampled.
- Each memory state moves to the next state of its sequence only on `mem_ack`.
- `ST_FETCH_VEC` and `ST_POP_PC` go to `ST_FINISH` on `mem_ack`.
- `ST_FINISH` always returns to idle.

Top module: `exc_frame_seq`

## Requirements
- R1: After reset, `busy`, `done`, `mem_req` and `mem_we` are low.
- R2: The descriptor word (the second longword written on entry) is laid out as follows:
  - bit 31 is 0 and bit 30 is 1;
  - bits 29:28 hold `sp_in[1:0]`;
  - bits 27:16 hold `exc_idx`×4;
  - bits 15:0 hold `sr_in`.
- R3: Entry makes exactly three memory accesses, in this order:
  - a write of the return address to A−4, where A is `sp_in` with its two low bits cleared;
  - a write of the descriptor to A−8;
  - a read at `vbr_in`+`exc_idx`×4.
  At `done`, `pc_out` equals the data read and `sp_out` equals A−8.
- R4: The return address written on entry is `pc_in`+2 when `exc_idx` is 32 to 47 and `hw_irq` is low; otherwise it is `pc_in`.
- R5: The status register reported on entry always has bit 13 (supervisor) set. When `hw_irq` is high, bits 10:8 are also replaced by `irq_level` and bit 12 is cleared. All other bits pass unchanged.
- R6: Return makes two reads, first at `sp_in` and then at `sp_in`+4. At `done`, the outputs are:
  - `sr_out` = bits 15:0 of the first word;
  - `pc_out` = the second word;
  - `sp_out` = (`sp_in` OR first-word bits 29:28) + 8.
- R7: While `mem_req` is high without `mem_ack`, the request, direction and address stay unchanged in the next cycle. Every write address is longword-aligned.
- R8: `busy` rises the cycle after an accepted start and stays high through the single cycle in which `done` is high. It falls the cycle after that.
- R9: Start pulses are ignored while `busy` is high, including changed inputs. When both starts arrive together in idle, entry is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_entry | input | 1 | Begin an exception entry |
| start_return | input | 1 | Begin a return from exception |
| hw_irq | input | 1 | Entry is a hardware interrupt |
| irq_level | input | 3 | Pending interrupt priority |
| exc_idx | input | 8 | Exception index |
| sr_in | input | 16 | Current status register |
| sp_in | input | 32 | Current stack pointer |
| pc_in | input | 32 | Current program counter |
| vbr_in | input | 32 | Vector table base |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Access byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completed |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| sr_out | output | 16 | Resulting status register |
| sp_out | output | 32 | Resulting stack pointer |
| pc_out | output | 32 | Resulting program counter |

## Verification
A wrong state shows up at the memory port as soon as the state is entered. It appears as a write where a read belongs, a wrong address, or a request that never appears, so the access log reveals it within one access. Corrupted captured inputs or descriptor bits are visible only at `done`, when `sr_out`, `sp_out` or `pc_out` differ from the values predicted. The round trip from an entry at a misaligned pointer back through a return exposes a misplaced misalignment field within one entry-return pair.

// File: rtl/exc_frame_pkg.sv
package exc_frame_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_PC,
        ST_PUSH_FMT,
        ST_FETCH_VEC,
        ST_POP_FMT,
        ST_POP_PC,
        ST_FINISH
    } seq_state_t;

    localparam int SR_W       = 16;
    localparam int SUPER_BIT  = 13;
    localparam int MASTER_BIT = 12;
    localparam int MASK_LSB   = 8;
    localparam int LEVEL_W    = 3;
endpackage

// File: rtl/exc_fmt_pack.sv
module exc_fmt_pack
    import exc_frame_pkg::*;
#(
    parameter int IDX_W      = 8,
    parameter int TRAP_FIRST = 32,
    parameter int TRAP_NUM   = 16
) (
    input  logic [SR_W-1:0]    sr_in,
    input  logic [31:0]        sp_in,
    input  logic [31:0]        pc_in,
    input  logic [31:0]        vbr_in,
    input  logic [IDX_W-1:0]   idx,
    input  logic               hw,
    input  logic [LEVEL_W-1:0] level,
    output logic [31:0]        fmt_word,
    output logic [31:0]        ret_addr,
    output logic [31:0]        push_pc_addr,
    output logic [31:0]        frame_sp,
    output logic [31:0]        vec_addr,
    output logic [SR_W-1:0]    sr_entry
);
    localparam int PAD_W = 12 - IDX_W - 2;

    logic [31:0] aligned;
    logic        is_trap;

    assign aligned      = {sp_in[31:2], 2'b00};
    assign push_pc_addr = aligned - 32'd4;
    assign frame_sp     = aligned - 32'd8;
    assign vec_addr     = vbr_in + {{(30-IDX_W){1'b0}}, idx, 2'b00};
    assign fmt_word     = {2'b01, sp_in[1:0], {PAD_W{1'b0}}, idx, 2'b00, sr_in};
    assign is_trap      = !hw && (int'(idx) >= TRAP_FIRST) && (int'(idx) < TRAP_FIRST + TRAP_NUM);
    assign ret_addr     = is_trap ? pc_in + 32'd2 : pc_in;

    always_comb begin
        sr_entry = sr_in;
        sr_entry[SUPER_BIT] = 1'b1;
        if (hw) begin
            sr_entry[MASK_LSB +: LEVEL_W] = level;
            sr_entry[MASTER_BIT] = 1'b0;
        end
    end
endmodule

// File: rtl/exc_frame_unpack.sv
module exc_frame_unpack
    import exc_frame_pkg::*;
(
    input  logic [31:0]     frame_sp,
    input  logic [1:0]      mis_bits,
    input  logic [SR_W-1:0] saved_sr,
    output logic [31:0]     restored_sp,
    output logic [SR_W-1:0] restored_sr
);
    assign restored_sp = (frame_sp | {30'b0, mis_bits}) + 32'd8;
    assign restored_sr = saved_sr;
endmodule

// File: rtl/exc_frame_seq.sv
module exc_frame_seq
    import exc_frame_pkg::*;
#(
    parameter int IDX_W      = 8,
    parameter int TRAP_FIRST = 32,
    parameter int TRAP_NUM   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_entry,
    input  logic               start_return,
    input  logic               hw_irq,
    input  logic [LEVEL_W-1:0] irq_level,
    input  logic [IDX_W-1:0]   exc_idx,
    input  logic [SR_W-1:0]    sr_in,
    input  logic [31:0]        sp_in,
    input  logic [31:0]        pc_in,
    input  logic [31:0]        vbr_in,
    output logic               mem_req,
    output logic               mem_we,
    output logic [31:0]        mem_addr,
    output logic [31:0]        mem_wdata,
    input  logic               mem_ack,
    input  logic [31:0]        mem_rdata,
    output logic               busy,
    output logic               done,
    output logic [SR_W-1:0]    sr_out,
    output logic [31:0]        sp_out,
    output logic [31:0]        pc_out
);
    seq_state_t state, state_nx;

    logic [SR_W-1:0]    cap_sr;
    logic [31:0]        cap_sp, cap_pc, cap_vbr;
    logic [IDX_W-1:0]   cap_idx;
    logic               cap_hw;
    logic [LEVEL_W-1:0] cap_lvl;
    logic [1:0]         saved_mis;
    logic [SR_W-1:0]    saved_sr;

    logic [31:0]     fmt_word, ret_addr, push_pc_addr, frame_sp, vec_addr;
    logic [SR_W-1:0] sr_entry;
    logic [31:0]     restored_sp;
    logic [SR_W-1:0] restored_sr;

    exc_fmt_pack #(.IDX_W(IDX_W), .TRAP_FIRST(TRAP_FIRST), .TRAP_NUM(TRAP_NUM)) u_pack (
        .sr_in(cap_sr), .sp_in(cap_sp), .pc_in(cap_pc), .vbr_in(cap_vbr),
        .idx(cap_idx), .hw(cap_hw), .level(cap_lvl),
        .fmt_word(fmt_word), .ret_addr(ret_addr), .push_pc_addr(push_pc_addr),
        .frame_sp(frame_sp), .vec_addr(vec_addr), .sr_entry(sr_entry)
    );

    exc_frame_unpack u_unpack (
        .frame_sp(cap_sp), .mis_bits(saved_mis), .saved_sr(saved_sr),
        .restored_sp(restored_sp), .restored_sr(restored_sr)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start_entry)       state_nx = ST_PUSH_PC;
                else if (start_return) state_nx = ST_POP_FMT;
            end
            ST_PUSH_PC:   if (mem_ack) state_nx = ST_PUSH_FMT;
            ST_PUSH_FMT:  if (mem_ack) state_nx = ST_FETCH_VEC;
            ST_FETCH_VEC: if (mem_ack) state_nx = ST_FINISH;
            ST_POP_FMT:   if (mem_ack) state_nx = ST_POP_PC;
            ST_POP_PC:    if (mem_ack) state_nx = ST_FINISH;
            ST_FINISH:    state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        busy      = 1'b1;
        done      = 1'b0;
        unique case (state)
            ST_IDLE:      busy = 1'b0;
            ST_PUSH_PC:   begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = push_pc_addr; mem_wdata = ret_addr; end
            ST_PUSH_FMT:  begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = frame_sp; mem_wdata = fmt_word; end
            ST_FETCH_VEC: begin mem_req = 1'b1; mem_addr = vec_addr; end
            ST_POP_FMT:   begin mem_req = 1'b1; mem_addr = cap_sp; end
            ST_POP_PC:    begin mem_req = 1'b1; mem_addr = cap_sp + 32'd4; end
            ST_FINISH:    done = 1'b1;
            default:      busy = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_sr <= '0; cap_sp <= '0; cap_pc <= '0; cap_vbr <= '0;
            cap_idx <= '0; cap_hw <= 1'b0; cap_lvl <= '0;
            saved_mis <= '0; saved_sr <= '0;
            sr_out <= '0; sp_out <= '0; pc_out <= '0;
        end else begin
            if (state == ST_IDLE && (start_entry || start_return)) begin
                cap_sr  <= sr_in;
                cap_sp  <= sp_in;
                cap_pc  <= pc_in;
                cap_vbr <= vbr_in;
                cap_idx <= exc_idx;
                cap_hw  <= hw_irq;
                cap_lvl <= irq_level;
            end
            if (state == ST_POP_FMT && mem_ack) begin
                saved_mis <= mem_rdata[29:28];
                saved_sr  <= mem_rdata[SR_W-1:0];
            end
            if (state == ST_FETCH_VEC && mem_ack) begin
                pc_out <= mem_rdata;
                sp_out <= frame_sp;
                sr_out <= sr_entry;
            end
            if (state == ST_POP_PC && mem_ack) begin
                pc_out <= mem_rdata;
                sp_out <= restored_sp;
                sr_out <= restored_sr;
            end
        end
    end
endmodule

// File: rtl/exc_frame_chk.sv
module exc_frame_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start_entry,
    input logic        start_return,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic        mem_ack,
    input logic        busy,
    input logic        done,
    input logic        super_flag
);
    logic entry_run;

    always_ff @(posedge clk) begin
        if (!rst_n)                        entry_run <= 1'b0;
        else if (!busy && start_entry)     entry_run <= 1'b1;
        else if (!busy && start_return)    entry_run <= 1'b0;
    end

    // R1
    idle_after_reset_chk: assert property (@(posedge clk) $rose(rst_n) |-> !busy && !mem_req);

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R7
    write_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_addr[1:0] == 2'b00);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done && !busy);

    // R8
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> busy && !mem_req);

    // R8
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> $past(done));

    // R9
    entry_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && start_entry |=> busy && mem_req && mem_we);

    // R6
    return_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start_entry && start_return |=> busy && mem_req && !mem_we);

    // R5
    super_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && entry_run |-> super_flag);
endmodule

bind exc_frame_seq exc_frame_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start_entry(start_entry), .start_return(start_return),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .busy(busy), .done(done), .super_flag(sr_out[13])
);

// File: tb/exc_frame_seq_bench.sv
`timescale 1ns/100ps
module exc_frame_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_entry = 1'b0, start_return = 1'b0, hw_irq = 1'b0;
    logic [2:0]  irq_level = '0;
    logic [7:0]  exc_idx = '0;
    logic [15:0] sr_in = '0;
    logic [31:0] sp_in = '0, pc_in = '0, vbr_in = '0;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic        busy, done;
    logic [15:0] sr_out;
    logic [31:0] sp_out, pc_out;

    int checks = 0, errors = 0;
    int ack_lat = 0, wait_cnt = 0, acc_cnt = 0;
    logic [31:0] log_addr [0:7];
    logic [31:0] log_data [0:7];
    logic        log_we   [0:7];
    logic [31:0] mem [logic [31:0]];

    always #2.5 clk = ~clk;

    exc_frame_seq u_exc_frame_seq (
        .clk(clk), .rst_n(rst_n), .start_entry(start_entry), .start_return(start_return),
        .hw_irq(hw_irq), .irq_level(irq_level), .exc_idx(exc_idx), .sr_in(sr_in),
        .sp_in(sp_in), .pc_in(pc_in), .vbr_in(vbr_in), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .sr_out(sr_out), .sp_out(sp_out), .pc_out(pc_out)
    );

    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
            wait_cnt = 0;
        end else if (mem_req) begin
            if (wait_cnt >= ack_lat) begin
                mem_ack = 1'b1;
                if (acc_cnt < 8) begin
                    log_addr[acc_cnt] = mem_addr;
                    log_we[acc_cnt]   = mem_we;
                    log_data[acc_cnt] = mem_wdata;
                end
                if (mem_we) mem[mem_addr] = mem_wdata;
                else        mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
                acc_cnt++;
            end else begin
                wait_cnt++;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_done();
        int n = 0;
        do begin
            @(posedge clk); #1;
            n++;
        end while (!done && n < 300);
        if (!done) check("R8 watchdog", 32'd0, 32'd1);
    endtask

    task automatic pulse(input logic ent, input logic ret);
        @(posedge clk); #1;
        start_entry = ent; start_return = ret;
        @(posedge clk); #1;
        start_entry = 1'b0; start_return = 1'b0;
    endtask

    task automatic setup(input logic [15:0] sr, input logic [31:0] sp, input logic [31:0] pc,
                         input logic [7:0] idx, input logic hw, input logic [2:0] lvl,
                         input logic [31:0] vbr);
        sr_in = sr; sp_in = sp; pc_in = pc; exc_idx = idx;
        hw_irq = hw; irq_level = lvl; vbr_in = vbr;
    endtask

    task automatic entry_case(input string tag, input logic [15:0] sr, input logic [31:0] sp,
                              input logic [31:0] pc, input logic [7:0] idx, input logic hw,
                              input logic [2:0] lvl, input logic [31:0] exp_ret,
                              input logic [31:0] exp_fmt, input logic [15:0] exp_sr);
        logic [31:0] al;
        al = {sp[31:2], 2'b00};
        mem[32'h0000_8000 + {22'b0, idx, 2'b00}] = 32'hA000_0000 + {24'b0, idx};
        setup(sr, sp, pc, idx, hw, lvl, 32'h0000_8000);
        acc_cnt = 0;
        pulse(1'b1, 1'b0);
        wait_done();
        check({tag, " R8 busy with done"}, {31'b0, busy}, 32'd1);
        check({tag, " R3 access count"}, acc_cnt, 32'd3);
        check({tag, " R3 push pc addr"}, log_addr[0], al - 32'd4);
        check({tag, " R4 return address"}, log_data[0], exp_ret);
        check({tag, " R3 push fmt addr"}, log_addr[1], al - 32'd8);
        check({tag, " R2 format word"}, log_data[1], exp_fmt);
        check({tag, " R3 vector read"}, {log_we[2], log_addr[2][30:0]},
              {1'b0, 31'h0000_8000 + {21'b0, idx, 2'b00}});
        check({tag, " R3 pc_out"}, pc_out, 32'hA000_0000 + {24'b0, idx});
        check({tag, " R3 sp_out"}, sp_out, al - 32'd8);
        check({tag, " R5 sr_out"}, {16'b0, sr_out}, {16'b0, exp_sr});
        @(posedge clk); #1;
        check({tag, " R8 busy drops"}, {30'b0, busy, done}, 32'd0);
    endtask

    task automatic return_case(input string tag, input logic [31:0] sp, input logic [15:0] exp_sr,
                               input logic [31:0] exp_sp, input logic [31:0] exp_pc);
        setup(16'h0, sp, 32'h0, 8'h0, 1'b0, 3'h0, 32'h0);
        acc_cnt = 0;
        pulse(1'b0, 1'b1);
        wait_done();
        check({tag, " R6 access count"}, acc_cnt, 32'd2);
        check({tag, " R6 read order"}, {log_we[0], log_we[1]} == 2'b00 && log_addr[0] == sp
              && log_addr[1] == sp + 32'd4 ? 32'd1 : 32'd0, 32'd1);
        check({tag, " R6 sr_out"}, {16'b0, sr_out}, {16'b0, exp_sr});
        check({tag, " R6 sp_out"}, sp_out, exp_sp);
        check({tag, " R6 pc_out"}, pc_out, exp_pc);
        @(posedge clk); #1;
    endtask

    task automatic reset_case();
        #1;
        check("R1 busy", {31'b0, busy}, 32'd0);
        check("R1 done", {31'b0, done}, 32'd0);
        check("R1 mem_req", {30'b0, mem_req, mem_we}, 32'd0);
    endtask

    task automatic ignore_case();
        setup(16'h0004, 32'h0000_4000, 32'h0000_1234, 8'd6, 1'b0, 3'd0, 32'h0000_8000);
        mem[32'h0000_8018] = 32'h0000_6006;
        acc_cnt = 0;
        pulse(1'b1, 1'b0);
        setup(16'hFFFF, 32'h0000_0100, 32'h0, 8'd9, 1'b1, 3'd7, 32'h0);
        start_return = 1'b1; start_entry = 1'b1;
        @(posedge clk); #1;
        start_return = 1'b0; start_entry = 1'b0;
        wait_done();
        check("R9 ignored start count", acc_cnt, 32'd3);
        check("R9 ignored start sp", sp_out, 32'h0000_3FF8);
        check("R9 ignored start sr", {16'b0, sr_out}, 32'h0000_2004);
        check("R9 ignored start pc", pc_out, 32'h0000_6006);
        @(posedge clk); #1;
        check("R9 idle after", {31'b0, busy}, 32'd0);
    endtask

    task automatic both_case();
        setup(16'h0000, 32'h0000_5000, 32'h0000_0010, 8'd2, 1'b0, 3'd0, 32'h0000_8000);
        acc_cnt = 0;
        pulse(1'b1, 1'b1);
        wait_done();
        check("R9 entry wins count", acc_cnt, 32'd3);
        check("R9 entry wins first write", {31'b0, log_we[0]}, 32'd1);
        @(posedge clk); #1;
    endtask

    initial begin
        #100000;
        check("watchdog", 32'd0, 32'd1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        reset_case();
        @(posedge clk); #1;
        rst_n = 1'b1;
        reset_case();
        ack_lat = 0;
        entry_case("sw", 16'h0704, 32'h0000_2000, 32'h0000_0400, 8'd5, 1'b0, 3'd0,
                   32'h0000_0400, 32'h4014_0704, 16'h2704);
        ack_lat = 3;
        entry_case("trap", 16'h0010, 32'h0000_2402, 32'h0000_0500, 8'd35, 1'b0, 3'd0,
                   32'h0000_0502, 32'h608C_0010, 16'h2010);
        entry_case("trap_end", 16'h0000, 32'h0000_2400, 32'h0000_0600, 8'd48, 1'b0, 3'd0,
                   32'h0000_0600, 32'h40C0_0000, 16'h2000);
        ack_lat = 1;
        entry_case("hw", 16'h3200, 32'h0000_3003, 32'h0000_0700, 8'd25, 1'b1, 3'd5,
                   32'h0000_0700, 32'h7064_3200, 16'h2500);
        return_case("ret_hw", 32'h0000_2FF8, 16'h3200, 32'h0000_3003, 32'h0000_0700);
        ack_lat = 0;
        return_case("ret_sw", 32'h0000_1FF8, 16'h0704, 32'h0000_2000, 32'h0000_0400);
        ignore_case();
        both_case();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule